// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Status Flags

This block is the byte-wide arithmetic and logic datapath of a small processor core. It takes two 8-bit operands and a 5-bit operation code. It returns an 8-bit result at once, from combinational logic. A registered set of six status flags is updated at the clock edge: half carry, sign, overflow, negative, zero and carry. The carry input of the chained operations is the carry flag held in that register. Each operation updates only its own subset of flags. A write-mask output shows which flags the present operation touches, and a write-back strobe tells the register file whether the result is to be stored.

Two word operations add a 6-bit unsigned immediate to a 16-bit register pair, or subtract it. They use the same 8-bit adder over two consecutive enabled cycles. The low byte is presented first, with the immediate on `opb`. The high byte follows, and the adder then absorbs the internal carry or borrow. The flags are written once, at the end of the second cycle, and they describe the whole 16-bit result. Register storage, instruction decode and memory access belong to the surrounding core.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_n` is low, and after it rises, all six flags read 0 and `word_hi` reads 0.
- R2: Flag bit layout: bit 5 is H, 4 is S, 3 is V, 2 is N, 1 is Z and 0 is C. Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 CMPC, 6 AND, 7 OR, 8 XOR, 9 INV, 10 NEG, 11 SHL, 12 SHR, 13 ROL, 14 ROR, 15 WADD, 16 WSUB. `flag_we` marks the flags that the present operation updates, and no other flag changes. With `en` low no flag changes. Codes 17 to 31 update no flag, drive `res` to 0 and keep `res_we` low.
- R3: ADD returns a+b and ADC returns a+b+C. Both update all six flags: C is the carry out of bit 7, H the carry out of bit 3, and V signals signed overflow.
- R4: SUB returns a−b and SBC returns a−b−C, where an immediate operand is simply presented on `opb`. Both update all six flags: C is the borrow out of bit 7 and H the borrow out of bit 3. For SBC, Z ends up 1 only if it was already 1 and the new result is zero.
- R5: CMP and CMPC produce the same flags as SUB and SBC, including the Z chaining of CMPC, and keep `res_we` low.
- R6: AND, OR and XOR update only Z, N, S and V, with V cleared. H and C keep their values.
- R7: INV returns 0xFF−a, sets C to 1, clears V and updates Z, N and S. H is kept.
- R8: NEG returns 0x00−a and updates all six flags. C is 1 unless a is 0, V is 1 only for a = 0x80, and H is the borrow out of bit 3.
- R9: SHL shifts left with a 0 into bit 0 and bit 7 into C. SHR shifts right with a 0 into bit 7 and bit 0 into C. Both set V to N XOR C, taken after the operation, and keep H.
- R10: ROL shifts C into bit 0 and bit 7 into C. ROR shifts C into bit 7 and bit 0 into C. Both set V to N XOR C, taken after the operation, and keep H.
- R11: Whenever S is written, its new value equals the new N XOR the new V.
- R12: WADD and WSUB take two enabled cycles with the same code. The first cycle has `word_hi` at 0, `res` equal to the low byte of the pair plus or minus the immediate `opb[5:0]`, and no flag written. The second cycle has `word_hi` at 1, takes the high byte on `opa` and returns the high result byte. It writes C, Z, N, V and S for the full 16-bit result and keeps H. `res_we` is high in both cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Operation valid this cycle; flags update at the edge |
| op | input | 5 | Operation code |
| opa | input | 8 | Destination operand (low or high pair byte in word operations) |
| opb | input | 8 | Source operand or immediate |
| res | output | 8 | Combinational result |
| res_we | output | 1 | Result is to be written back |
| flag_we | output | 6 | Flags the present operation updates |
| word_hi | output | 1 | Second cycle of a word operation is due |
| flags | output | 6 | Registered status flags {H,S,V,N,Z,C} |

## Verification
All 256 first operands are tried with 16 second operands per binary operation. The second operand is a mix of the first and a spread stride, so it reaches sign-boundary and nibble-carry values. Each carry-consuming operation and each shift or rotate is preceded by one of the four carry/zero combinations. This separates the plain and chained variants, and it shows the Z chaining and the carry insertion. Word operations run 64 pair values against all 64 immediates in both directions. The pair values include 0x0000, 0x7FFF, 0x8000 and 0xFFFF, so the 16-bit wrap, the signed overflow and the zero result across both bytes are each reached. Unused codes and idle cycles between operations show that the flags hold.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned OPW   = 5;
    localparam int unsigned NFLAG = 6;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CMPC = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_INV  = 5'd9,
        OP_NEG  = 5'd10,
        OP_SHL  = 5'd11,
        OP_SHR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_WADD = 5'd15,
        OP_WSUB = 5'd16
    } alu_op_e;

    // bit 5 down to bit 0
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam logic [NFLAG-1:0] MASK_ALL   = 6'b111111;
    localparam logic [NFLAG-1:0] MASK_LOGIC = 6'b011110;
    localparam logic [NFLAG-1:0] MASK_NOH   = 6'b011111;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] r,
    output logic          c_out,
    output logic          h_out,
    output logic          v_out
);
    localparam int unsigned HW = DW / 2;

    logic [DW-1:0] ye;
    logic          ci;
    logic [DW:0]   sum;
    logic [HW:0]   low;

    // subtraction as x + ~y + ~borrow; carries inverted back into borrows
    always_comb begin
        ye    = sub ? ~y : y;
        ci    = cin ^ sub;
        sum   = {1'b0, x} + {1'b0, ye} + {{DW{1'b0}}, ci};
        low   = {1'b0, x[HW-1:0]} + {1'b0, ye[HW-1:0]} + {{HW{1'b0}}, ci};
        r     = sum[DW-1:0];
        c_out = sum[DW] ^ sub;
        h_out = low[HW] ^ sub;
        v_out = (x[DW-1] == ye[DW-1]) && (r[DW-1] != x[DW-1]);
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin,
    output logic [DW-1:0] r,
    output logic          c_out,
    output logic          shift
);
    always_comb begin
        r     = '0;
        c_out = cin;
        shift = 1'b0;
        case (op)
            OP_AND: r = x & y;
            OP_OR:  r = x | y;
            OP_XOR: r = x ^ y;
            OP_INV: begin
                r     = ~x;
                c_out = 1'b1;
            end
            OP_SHL: begin
                r     = {x[DW-2:0], 1'b0};
                c_out = x[DW-1];
                shift = 1'b1;
            end
            OP_SHR: begin
                r     = {1'b0, x[DW-1:1]};
                c_out = x[0];
                shift = 1'b1;
            end
            OP_ROL: begin
                r     = {x[DW-2:0], cin};
                c_out = x[DW-1];
                shift = 1'b1;
            end
            OP_ROR: begin
                r     = {cin, x[DW-1:1]};
                c_out = x[0];
                shift = 1'b1;
            end
            default: r = '0;
        endcase
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned IMMW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [OPW-1:0]   op,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    output logic [DW-1:0]    res,
    output logic             res_we,
    output logic [NFLAG-1:0] flag_we,
    output logic             word_hi,
    output logic [NFLAG-1:0] flags
);
    typedef struct packed {
        flags_t flg;
        logic   hi;   // second word cycle pending
        logic   wc;   // carry/borrow out of low byte
        logic   lz;   // low byte result was zero
    } state_t;

    state_t st_d, st_q;

    alu_op_e opc;
    assign opc = alu_op_e'(op);

    logic [DW-1:0]    ax, ay, ar, br;
    logic             acin, asub, ac, ah, av, bc, bshift;
    logic             arith_sel, chain, is_word, we_raw;
    logic [NFLAG-1:0] mask;
    flags_t           cand;
    logic [NFLAG-1:0] cand_v, cur_v, merged;

    // operand steering and per-operation flag mask
    always_comb begin
        ax        = opa;
        ay        = opb;
        acin      = 1'b0;
        asub      = 1'b0;
        arith_sel = 1'b1;
        chain     = 1'b0;
        is_word   = 1'b0;
        we_raw    = 1'b0;
        mask      = '0;
        case (opc)
            OP_ADD: begin
                mask = MASK_ALL; we_raw = 1'b1;
            end
            OP_ADC: begin
                acin = st_q.flg.c; mask = MASK_ALL; we_raw = 1'b1;
            end
            OP_SUB: begin
                asub = 1'b1; mask = MASK_ALL; we_raw = 1'b1;
            end
            OP_SBC: begin
                asub = 1'b1; acin = st_q.flg.c; chain = 1'b1;
                mask = MASK_ALL; we_raw = 1'b1;
            end
            OP_CMP: begin
                asub = 1'b1; mask = MASK_ALL;
            end
            OP_CMPC: begin
                asub = 1'b1; acin = st_q.flg.c; chain = 1'b1; mask = MASK_ALL;
            end
            OP_AND, OP_OR, OP_XOR: begin
                arith_sel = 1'b0; mask = MASK_LOGIC; we_raw = 1'b1;
            end
            OP_INV, OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                arith_sel = 1'b0; mask = MASK_NOH; we_raw = 1'b1;
            end
            OP_NEG: begin
                ax = '0; ay = opa; asub = 1'b1; mask = MASK_ALL; we_raw = 1'b1;
            end
            OP_WADD, OP_WSUB: begin
                is_word = 1'b1;
                asub    = (opc == OP_WSUB);
                we_raw  = 1'b1;
                if (!st_q.hi) begin
                    ay   = {{(DW-IMMW){1'b0}}, opb[IMMW-1:0]};
                    mask = '0;
                end else begin
                    ay   = '0;
                    acin = st_q.wc;
                    mask = MASK_NOH;
                end
            end
            default: arith_sel = 1'b0;
        endcase
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .x     (ax),
        .y     (ay),
        .cin   (acin),
        .sub   (asub),
        .r     (ar),
        .c_out (ac),
        .h_out (ah),
        .v_out (av)
    );

    alu8_bitops #(.DW(DW)) u_bitops (
        .op    (opc),
        .x     (opa),
        .y     (opb),
        .cin   (st_q.flg.c),
        .r     (br),
        .c_out (bc),
        .shift (bshift)
    );

    assign res     = arith_sel ? ar : br;
    assign res_we  = en & we_raw;
    assign flag_we = en ? mask : '0;

    // candidate flag values before masking
    always_comb begin
        cand.n = res[DW-1];
        cand.h = ah;
        cand.c = arith_sel ? ac : bc;
        if (arith_sel)   cand.v = av;
        else if (bshift) cand.v = res[DW-1] ^ bc;
        else             cand.v = 1'b0;
        if (is_word)     cand.z = st_q.lz & (res == '0);
        else if (chain)  cand.z = st_q.flg.z & (res == '0);
        else             cand.z = (res == '0);
        cand.s = cand.n ^ cand.v;
    end

    assign cand_v = cand;
    assign cur_v  = st_q.flg;

    for (genvar i = 0; i < NFLAG; i++) begin : g_merge
        assign merged[i] = flag_we[i] ? cand_v[i] : cur_v[i];
    end

    always_comb begin
        st_d     = st_q;
        st_d.flg = flags_t'(merged);
        if (en && is_word && !st_q.hi) begin
            st_d.hi = 1'b1;
            st_d.wc = ac;
            st_d.lz = (ar == '0);
        end else begin
            st_d.hi = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags   = st_q.flg;
    assign word_hi = st_q.hi;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [OPW-1:0]   op,
    input logic             res_we,
    input logic [NFLAG-1:0] flag_we,
    input logic             word_hi,
    input logic [NFLAG-1:0] flags
);
    localparam int unsigned FH = 5, FS = 4, FV = 3, FN = 2, FC = 0;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> flags == $past(flags));

    p_mask_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((flags ^ $past(flags)) & ~$past(flag_we)) == '0);

    p_cmp_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en && (op == OP_CMP || op == OP_CMPC) |-> !res_we);

    p_logic_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en && (op == OP_AND || op == OP_OR || op == OP_XOR)
        |=> !flags[FV] && flags[FC] == $past(flags[FC]) && flags[FH] == $past(flags[FH]));

    p_inv_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en && op == OP_INV |=> flags[FC] && !flags[FV]);

    p_shift_v_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en && (op == OP_SHL || op == OP_SHR || op == OP_ROL || op == OP_ROR)
        |=> flags[FV] == (flags[FN] ^ flags[FC]));

    p_sign_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en && flag_we[FS] |=> flags[FS] == (flags[FN] ^ flags[FV]));

    p_word_enter_r12: assert property (@(posedge clk) disable iff (!rst_n)
        en && (op == OP_WADD || op == OP_WSUB) && !word_hi |=> word_hi);

    p_word_lo_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        en && (op == OP_WADD || op == OP_WSUB) && !word_hi |-> flag_we == '0);

    p_word_leave_r12: assert property (@(posedge clk) disable iff (!rst_n)
        word_hi |=> !word_hi);

endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .op      (op),
    .res_we  (res_we),
    .flag_we (flag_we),
    .word_hi (word_hi),
    .flags   (flags)
);

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] opa = '0, opb = '0;
    logic [7:0] res;
    logic       res_we, word_hi;
    logic [5:0] flag_we, flags;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    logic [5:0] exp_f = '0;

    always #10 clk = ~clk;

    alu8_flags uut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
        .res(res), .res_we(res_we), .flag_we(flag_we), .word_hi(word_hi), .flags(flags)
    );

    function automatic string tag_of(input int o);
        case (o)
            0, 1:    return "R3 R11";
            2, 3:    return "R4 R11";
            4, 5:    return "R5 R11";
            6, 7, 8: return "R6 R11";
            9:       return "R7 R11";
            10:      return "R8 R11";
            11, 12:  return "R9 R11";
            13, 14:  return "R10 R11";
            default: return "R2";
        endcase
    endfunction

    // reference computed with integer arithmetic; flag order {H,S,V,N,Z,C}
    task automatic model(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [5:0] f, output logic [7:0] r, output logic we,
                         output logic [5:0] m, output logic [5:0] nf);
        int ia, ib, ci, s, sa, sb, sv;
        logic c, h, v, z, n;
        logic [5:0] nv;
        ia = a; ib = b; sa = $signed(a); sb = $signed(b);
        r = '0; we = 1'b0; m = '0;
        c = f[0]; h = f[5]; v = f[3];
        z = 1'b0;
        case (o)
            5'd0, 5'd1: begin
                ci = (o == 5'd1 && f[0]) ? 1 : 0;
                s = ia + ib + ci; r = s[7:0];
                c = s > 255;
                h = ((ia % 16) + (ib % 16) + ci) > 15;
                sv = sa + sb + ci; v = (sv > 127) || (sv < -128);
                m = '1; we = 1'b1; z = (r == 0);
            end
            5'd2, 5'd3, 5'd4, 5'd5: begin
                ci = ((o == 5'd3 || o == 5'd5) && f[0]) ? 1 : 0;
                s = ia - ib - ci; r = s[7:0];
                c = s < 0;
                h = (ia % 16) < ((ib % 16) + ci);
                sv = sa - sb - ci; v = (sv > 127) || (sv < -128);
                m = '1; we = (o < 5'd4);
                z = (r == 0) && ((o == 5'd3 || o == 5'd5) ? f[1] : 1'b1);
            end
            5'd6, 5'd7, 5'd8: begin
                r = (o == 5'd6) ? (a & b) : (o == 5'd7) ? (a | b) : (a ^ b);
                v = 1'b0; m = 6'b011110; we = 1'b1; z = (r == 0);
            end
            5'd9: begin
                r = 8'(255 - ia); c = 1'b1; v = 1'b0;
                m = 6'b011111; we = 1'b1; z = (r == 0);
            end
            5'd10: begin
                s = 0 - ia; r = s[7:0]; c = s < 0;
                h = (ia % 16) > 0; sv = 0 - sa; v = sv > 127;
                m = '1; we = 1'b1; z = (r == 0);
            end
            5'd11, 5'd12, 5'd13, 5'd14: begin
                if (o == 5'd11 || o == 5'd13) begin
                    r = 8'((ia * 2) % 256 + ((o == 5'd13 && f[0]) ? 1 : 0));
                    c = ia >= 128;
                end else begin
                    r = 8'(ia / 2 + ((o == 5'd14 && f[0]) ? 128 : 0));
                    c = (ia % 2) != 0;
                end
                v = r[7] ^ c; m = 6'b011111; we = 1'b1; z = (r == 0);
            end
            default: begin
            end
        endcase
        n  = r[7];
        nv = {h, n ^ v, v, n, z, c};
        nf = (nv & m) | (f & ~m);
    endtask

    task automatic check_step(input string tag, input logic [4:0] o, input logic [7:0] a,
                              input logic [7:0] b, input logic [7:0] er, input logic ewe,
                              input logic [5:0] em, input logic [5:0] enf, input logic ehi);
        logic [7:0] gr; logic gwe, ghi; logic [5:0] gm, gf;
        @(negedge clk);
        en = 1'b1; op = o; opa = a; opb = b;
        #1;
        gr = res; gwe = res_we; gm = flag_we; ghi = word_hi;
        @(posedge clk);
        #1;
        en = 1'b0;
        gf = flags;
        vectors++;
        if (gr !== er || gwe !== ewe || gm !== em || ghi !== ehi || gf !== enf) begin
            miscompares++;
            $display("FAIL %s op=%0d a=%h b=%h: res %h exp %h, we %b exp %b, mask %b exp %b, hi %b exp %b, flags %b exp %b",
                     tag, o, a, b, gr, er, gwe, ewe, gm, em, ghi, ehi, gf, enf);
        end
        exp_f = enf;
    endtask

    task automatic do_byte(input string tag, input logic [4:0] o, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r; logic we; logic [5:0] m, nf;
        model(o, a, b, exp_f, r, we, m, nf);
        check_step(tag, o, a, b, r, we, m, nf, 1'b0);
    endtask

    // prepares Z and C: 3 -> Z=1,C=1; 2 -> Z=1,C=0; 1 -> Z=0,C=1; 0 -> both 0
    task automatic set_zc(input int k);
        case (k)
            3: do_byte("R7", 5'd9, 8'hFF, 8'h00);
            2: do_byte("R3", 5'd0, 8'h00, 8'h00);
            1: do_byte("R4", 5'd2, 8'h00, 8'h01);
            default: do_byte("R3", 5'd0, 8'h01, 8'h00);
        endcase
    endtask

    task automatic do_word(input bit sub, input logic [15:0] w, input logic [5:0] imm);
        int r16, sw;
        logic [15:0] rv;
        logic v, c, n, z;
        logic [4:0] o;
        o = sub ? 5'd16 : 5'd15;
        if (!sub) begin
            r16 = int'(w) + int'(imm); c = r16 > 65535;
            sw = int'($signed(w)) + int'(imm); v = sw > 32767;
        end else begin
            r16 = int'(w) - int'(imm); c = r16 < 0;
            sw = int'($signed(w)) - int'(imm); v = sw < -32768;
        end
        rv = r16[15:0]; n = rv[15]; z = (rv == 0);
        check_step("R12", o, w[7:0], {2'b00, imm}, rv[7:0], 1'b1, 6'b000000, exp_f, 1'b0);
        check_step("R12", o, w[15:8], 8'h00, rv[15:8], 1'b1, 6'b011111,
                   {exp_f[5], n ^ v, v, n, z, c}, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, actual hung, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (flags !== 6'b0 || word_hi !== 1'b0) begin   // R1
            miscompares++;
            $display("FAIL R1 reset: flags %b hi %b exp 000000 0", flags, word_hi);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        vectors++;
        if (flags !== 6'b0 || word_hi !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 after release: flags %b hi %b exp 000000 0", flags, word_hi);
        end

        // R2: idle cycle and unused codes leave the flags alone
        do_byte("R3", 5'd0, 8'h7F, 8'h01);
        @(negedge clk);
        en = 1'b0; op = 5'd0; opa = 8'h00; opb = 8'h00;
        @(posedge clk);
        #1;
        vectors++;
        if (flags !== exp_f) begin
            miscompares++;
            $display("FAIL R2 idle: flags %b exp %b", flags, exp_f);
        end
        do_byte("R2", 5'd20, 8'h55, 8'h0F);
        do_byte("R2", 5'd31, 8'hFF, 8'hFF);
        do_byte("R2", 5'd17, 8'h00, 8'h80);

        // binary operations R3..R6
        for (int o = 0; o < 9; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    if (o == 1 || o == 3 || o == 5) set_zc((a + bi) % 4);
                    do_byte(tag_of(o), 5'(o), 8'(a), 8'((bi * 17 + a * 5) % 256));
                end
            end
        end

        // unary operations R7..R10
        for (int o = 9; o < 15; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 4; k++) begin
                    set_zc(k);
                    do_byte(tag_of(o), 5'(o), 8'(a), 8'h00);
                end
            end
        end

        // word operations R12
        for (int s = 0; s < 2; s++) begin
            for (int j = 0; j < 64; j++) begin
                case (j)
                    1: w = 16'h7FFF;
                    2: w = 16'h8000;
                    3: w = 16'h0000;
                    4: w = 16'hFFC1;
                    5: w = 16'hFFFF;
                    6: w = 16'h0020;
                    default: w = 16'((j * 1039) % 65536);
                endcase
                for (int imm = 0; imm < 64; imm++) begin
                    do_word(s != 0, w, 6'(imm));
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule